// File: doc/BRIEF.md
# Serial Register Access Slave Port

This block lets an external host reach a bank of thirty-two 8-bit registers over four wires: an active-low select, a serial clock, a data line into the block and a data line out of it. All four are treated as asynchronous to the block's own system clock. Select, serial clock and serial data pass through a chain of synchronizer flops before any logic sees them. Edges of the serial clock are found by comparing the synchronized value with its previous value.

Every access opens with an 8-bit command, shifted least significant bit first. The command carries the direction, a register index, a reserved bit and a burst flag. Register data follows, also least significant bit first. Two static inputs choose which serial clock edge captures incoming bits and which edge moves the outgoing line. With the burst flag set, the access runs on through consecutive registers, and the index wraps past the top of the bank. When select rises, the access ends at once and the output enable drops.

Top module: `ser_reg_port`

## Requirements
- R1: After reset all registers read back as 0x00, and both `sdo` and `sdo_en` are low.
- R2: While `cs_n` is high, `sdo_en` is low no later than SYNC_STAGES+1 system clocks after the rise. While `cs_n` is low, `sdo_en` is high.
- R3: The command byte is shifted in LSB first. Bit 0 is the direction (1 read, 0 write), bits 5:1 are the register index, bit 6 must be 0, and bit 7 set means burst.
- R4: A write stores a data byte, received LSB first, into the indexed register. The store happens only after the eighth data bit.
- R5: On a read, bit 0 of the register is on `sdo` by the first output edge that follows the sample edge of the eighth command bit. Each later output edge moves to the next higher bit, and `sdo` holds its value between output edges.
- R6: With `ices` low, input bits are captured on rising `sclk` edges. With `ices` high, they are captured on falling edges.
- R7: With `oces` low, `sdo` moves on falling `sclk` edges. With `oces` high, it moves on rising edges.
- R8: In burst mode the register index steps by one after every complete data byte and wraps from 31 to 0. This holds for both reads and writes.
- R9: A command with bit 6 set is ignored. No register changes, and `sdo` stays low for the rest of the access.
- R10: If `cs_n` rises before a data byte is complete, no register is written, and the next access starts cleanly with a new command.
- R11: Without burst, only one data byte is transferred. Further write bits do not reach the next register, and after a read byte `sdo` stays low.
- R12: During the command byte `sdo` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| ices | input | 1 | Capture edge select: 0 rising, 1 falling |
| oces | input | 1 | Output edge select: 0 falling, 1 rising |
| sdo | output | 1 | Serial data out of the block |
| sdo_en | output | 1 | Output enable for the `sdo` pad driver |

## Verification
The bench builds the block with SYNC_STAGES = 2. It holds each serial clock phase for 8 system clocks, so the synchronizer delay plus the register reload always settle well inside one phase. With that margin, the bench can read `sdo` just before each output edge and predict the bit index exactly in all four edge-select combinations. Because the bank has only 32 entries, a four-byte burst that starts at index 30 reaches the wrap from 31 to 0 for writes and for reads. A single burst read covers the whole bank after reset.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;
    localparam int CMD_W  = ADDR_W + 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_DATA,
        ST_IGN,
        ST_DONE
    } srp_state_e;

    // command byte, MSB first in the packed order
    typedef struct packed {
        logic  burst;
        logic  rsvd;
        addr_t addr;
        logic  rd;
    } srp_cmd_t;

    function automatic srp_cmd_t decode_cmd(input logic [CMD_W-1:0] raw);
        return srp_cmd_t'(raw);
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= g_stg[s-1].q;
            end
        end
    end

    assign q_out = g_stg[STAGES-1].q;

endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import ser_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);

    word_t bank [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        word_t q;
        always_ff @(posedge clk) begin
            if (rst)                             q <= '0;
            else if (we && waddr == addr_t'(r))  q <= wdata;
        end
        assign bank[r] = q;
    end

    assign rdata = bank[raddr];

endmodule

// File: rtl/srp_engine.sv
module srp_engine
    import ser_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_s,
    input  logic       sclk_s,
    input  logic       sdi_s,
    input  logic       ices,
    input  logic       oces,
    input  word_t      rdata,
    output logic       we,
    output addr_t      waddr,
    output word_t      wdata,
    output addr_t      raddr,
    output logic       sdo,
    output logic       sdo_en,
    output logic       drive_ev,
    output logic       load_ev,
    output srp_state_e state_o,
    output logic       burst_o,
    output addr_t      addr_o
);

    localparam int MAXB = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int BC_W = $clog2(MAXB) + 1;

    logic             sclk_q;
    logic             rise, fall, sample_ev;
    srp_state_e       state;
    logic [BC_W-1:0]  bit_cnt;
    logic [BC_W-1:0]  tx_cnt;
    logic [CMD_W-2:0] cmd_sh;
    logic [CMD_W-1:0] cmd_nxt;
    srp_cmd_t         cmd;
    logic [DATA_W-2:0] rx_sh;
    word_t            rx_nxt;
    word_t            tx_sh;
    addr_t            addr;
    logic             rd, burst;
    logic             load_req, load_first, tx_first;
    logic             sdo_q, sdo_en_q;

    always_comb begin
        rise      = sclk_s & ~sclk_q;
        fall      = ~sclk_s & sclk_q;
        sample_ev = ices ? fall : rise;
        drive_ev  = oces ? rise : fall;
        cmd_nxt   = {sdi_s, cmd_sh};
        cmd       = decode_cmd(cmd_nxt);
        rx_nxt    = {sdi_s, rx_sh};
        load_ev   = (state == ST_DATA) && load_req;
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_CMD;
            bit_cnt    <= '0;
            tx_cnt     <= '0;
            cmd_sh     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            addr       <= '0;
            rd         <= 1'b0;
            burst      <= 1'b0;
            load_req   <= 1'b0;
            load_first <= 1'b0;
            tx_first   <= 1'b0;
            sdo_q      <= 1'b0;
            sdo_en_q   <= 1'b0;
            we         <= 1'b0;
            waddr      <= '0;
            wdata      <= '0;
        end else begin
            we       <= 1'b0;
            sdo_en_q <= ~cs_s;
            if (cs_s) begin
                state    <= ST_CMD;
                bit_cnt  <= '0;
                tx_cnt   <= '0;
                load_req <= 1'b0;
                tx_first <= 1'b0;
                sdo_q    <= 1'b0;
            end else begin
                unique case (state)
                    ST_CMD: begin
                        if (sample_ev) begin
                            cmd_sh <= cmd_nxt[CMD_W-1:1];
                            if (bit_cnt == BC_W'(CMD_W-1)) begin
                                bit_cnt <= '0;
                                if (cmd.rsvd) begin
                                    state <= ST_IGN;
                                end else begin
                                    state      <= ST_DATA;
                                    addr       <= cmd.addr;
                                    rd         <= cmd.rd;
                                    burst      <= cmd.burst;
                                    load_req   <= cmd.rd;
                                    load_first <= 1'b1;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + BC_W'(1);
                            end
                        end
                    end
                    ST_DATA: begin
                        if (rd) begin
                            if (load_req) begin
                                tx_sh      <= rdata;
                                sdo_q      <= rdata[0];
                                load_req   <= 1'b0;
                                tx_first   <= load_first;
                                load_first <= 1'b0;
                                tx_cnt     <= '0;
                            end else if (drive_ev) begin
                                if (tx_first) begin
                                    tx_first <= 1'b0;
                                end else if (tx_cnt == BC_W'(DATA_W-1)) begin
                                    tx_cnt <= '0;
                                    if (burst) begin
                                        addr     <= addr + addr_t'(1);
                                        load_req <= 1'b1;
                                    end else begin
                                        state <= ST_DONE;
                                        sdo_q <= 1'b0;
                                    end
                                end else begin
                                    tx_cnt <= tx_cnt + BC_W'(1);
                                    tx_sh  <= tx_sh >> 1;
                                    sdo_q  <= tx_sh[1];
                                end
                            end
                        end else if (sample_ev) begin
                            rx_sh <= rx_nxt[DATA_W-1:1];
                            if (bit_cnt == BC_W'(DATA_W-1)) begin
                                bit_cnt <= '0;
                                we      <= 1'b1;
                                waddr   <= addr;
                                wdata   <= rx_nxt;
                                if (burst) addr  <= addr + addr_t'(1);
                                else       state <= ST_DONE;
                            end else begin
                                bit_cnt <= bit_cnt + BC_W'(1);
                            end
                        end
                    end
                    default: sdo_q <= 1'b0;
                endcase
            end
        end
    end

    assign raddr   = addr;
    assign sdo     = sdo_q;
    assign sdo_en  = sdo_en_q;
    assign state_o = state;
    assign burst_o = burst;
    assign addr_o  = addr;

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    input  logic ices,
    input  logic oces,
    output logic sdo,
    output logic sdo_en
);

    logic [2:0] pins_raw, pins_s;
    logic       cs_sync;
    logic       wr_en;
    addr_t      wr_addr, rd_addr, eng_addr;
    word_t      wr_data, rd_data;
    logic       eng_drive, eng_load, eng_burst;
    srp_state_e eng_state;

    assign pins_raw = {cs_n, sclk, sdi};
    assign cs_sync  = pins_s[2];

    srp_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (pins_raw),
        .q_out(pins_s)
    );

    srp_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    srp_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (cs_sync),
        .sclk_s  (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .ices    (ices),
        .oces    (oces),
        .rdata   (rd_data),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr   (rd_addr),
        .sdo     (sdo),
        .sdo_en  (sdo_en),
        .drive_ev(eng_drive),
        .load_ev (eng_load),
        .state_o (eng_state),
        .burst_o (eng_burst),
        .addr_o  (eng_addr)
    );

endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import ser_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       cs_s,
    input logic       sdo,
    input logic       sdo_en,
    input logic       drive_ev,
    input logic       load_ev,
    input logic       we,
    input logic       burst,
    input addr_t      waddr,
    input addr_t      addr,
    input srp_state_e state
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 hi_cnt <= '0;
        else if (!cs_n)          hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
    end

    p_oe_off_r2: assert property (@(posedge clk) disable iff (rst)
        (hi_cnt > 8'(SYNC_STAGES)) |-> !sdo_en);

    p_sdo_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(drive_ev || load_ev || cs_s));

    p_burst_step_r8: assert property (@(posedge clk) disable iff (rst)
        (we && burst) |-> (addr == addr_t'(waddr + addr_t'(1))));

    p_ign_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGN) |-> (!sdo && !we));

    p_no_write_deselected_r10: assert property (@(posedge clk) disable iff (rst)
        we |-> !$past(cs_s));

    p_cmd_low_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD) |-> !sdo);

endmodule

bind ser_reg_port srp_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .cs_s    (cs_sync),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .drive_ev(eng_drive),
    .load_ev (eng_load),
    .we      (wr_en),
    .burst   (eng_burst),
    .waddr   (wr_addr),
    .addr    (eng_addr),
    .state   (eng_state)
);

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;
    import ser_reg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ices = 1'b0, oces = 1'b0;
    logic sdo, sdo_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_reg_port u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .ices(ices), .oces(oces), .sdo(sdo), .sdo_en(sdo_en)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    logic  cap[$];
    word_t wbuf[64];
    word_t model[NREG];
    word_t exp_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial clock period, idle level low; sdo is captured just
    // before the edge that moves it
    task automatic sck_cycle(input logic din);
        if (!ices) sdi = din;
        wclk(HALF_SCK);
        if (oces) cap.push_back(sdo);
        sclk = 1'b1;
        if (ices) sdi = din;
        wclk(HALF_SCK);
        if (!oces) cap.push_back(sdo);
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nbits, input int tail);
        cap.delete();
        cs_n = 1'b0;
        wclk(HALF_SCK);
        for (int i = 0; i < 8; i++) sck_cycle(cmd[i]);
        for (int i = 0; i < nbits; i++) sck_cycle(wbuf[i/8][i%8]);
        for (int i = 0; i < tail; i++) sck_cycle(1'b0);
        wclk(HALF_SCK);
        chk("R2 enable while selected", 32'(sdo_en), 32'd1);
        cs_n = 1'b1;
        wclk(HALF_SCK);
        chk("R2 tri-state after deselect", 32'(sdo_en), 32'd0);
    endtask

    // R3 layout: bit0 dir, bits5:1 index, bit6 reserved, bit7 burst
    function automatic logic [7:0] mk_cmd(input bit rd, input addr_t a, input bit burst, input bit rsvd);
        return {burst, rsvd, a, rd};
    endfunction

    function automatic int first_cycle();
        return (!oces && !ices) ? 9 : 10;
    endfunction

    task automatic write_regs(input addr_t a, input int n, input bit burst);
        xfer(mk_cmd(1'b0, a, burst, 1'b0), 8*n, 0);
        for (int b = 0; b < n; b++)
            if (burst || b == 0) model[addr_t'(int'(a) + b)] = wbuf[b];
    endtask

    task automatic read_regs(input addr_t a, input int n, input bit burst, input string req);
        int   base;
        logic any;
        word_t got;
        for (int b = 0; b < n; b++) exp_q.push_back(model[addr_t'(int'(a) + b)]);
        for (int b = 0; b < 64; b++) wbuf[b] = '0;
        xfer(mk_cmd(1'b1, a, burst, 1'b0), 8*n, 2);
        base = first_cycle();
        any = 1'b0;
        for (int c = 0; c < 7; c++) any |= cap[c];
        chk("R12 sdo low in command phase", 32'(any), 32'd0);
        for (int b = 0; b < n; b++) begin
            for (int k = 0; k < 8; k++) got[k] = cap[base - 1 + 8*b + k];
            chk(req, 32'(got), 32'(exp_q.pop_front()));
        end
        if (!burst) chk("R11 sdo low after single read byte", 32'(cap[base - 1 + 8]), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic any;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        for (int i = 0; i < 64; i++) wbuf[i] = '0;
        wclk(5);
        rst = 1'b0;
        wclk(2);
        chk("R1 sdo_en low after reset", 32'(sdo_en), 32'd0);
        chk("R1 sdo low after reset", 32'(sdo), 32'd0);

        // R1 and R8: whole bank after reset in one burst, wraps back to 0
        read_regs(5'd0, NREG + 1, 1'b1, "R1 R8 reset contents burst read");

        // R3 R4 R5 R6 R7: every edge-select combination
        for (int m = 0; m < 4; m++) begin
            ices = m[0];
            oces = m[1];
            wbuf[0] = 8'h5A + 8'(m * 8'h23);
            write_regs(addr_t'(4 + m), 1, 1'b0);
            read_regs(addr_t'(4 + m), 1, 1'b0, "R3 R4 R5 R6 R7 single access per edge mode");
        end

        // R8: burst write and read across the top of the bank
        ices = 1'b1; oces = 1'b0;
        wbuf[0] = 8'hC1; wbuf[1] = 8'h82; wbuf[2] = 8'h43; wbuf[3] = 8'h24;
        write_regs(5'd30, 4, 1'b1);
        read_regs(5'd0, 1, 1'b0, "R8 burst write wrapped to index 0");
        read_regs(5'd30, 4, 1'b1, "R8 burst read wrap");

        // R9: reserved bit set, write and read both ignored
        ices = 1'b0; oces = 1'b1;
        wbuf[0] = 8'hFF;
        xfer(mk_cmd(1'b0, 5'd3, 1'b0, 1'b1), 8, 2);
        any = 1'b0;
        foreach (cap[i]) any |= cap[i];
        chk("R9 sdo low during ignored write", 32'(any), 32'd0);
        read_regs(5'd3, 1, 1'b0, "R9 ignored write left register");
        xfer(mk_cmd(1'b1, 5'd4, 1'b0, 1'b1), 8, 2);
        any = 1'b0;
        foreach (cap[i]) any |= cap[i];
        chk("R9 sdo low during ignored read", 32'(any), 32'd0);

        // R10: select released after 5 data bits
        wbuf[0] = 8'hFF;
        xfer(mk_cmd(1'b0, 5'd9, 1'b0, 1'b0), 5, 0);
        read_regs(5'd9, 1, 1'b0, "R10 aborted write left register");

        // R11: second byte without burst must not spill
        ices = 1'b1; oces = 1'b1;
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
        write_regs(5'd12, 2, 1'b0);
        read_regs(5'd13, 1, 1'b0, "R11 no spill into next register");
        read_regs(5'd12, 1, 1'b0, "R11 single write stored");

        // R8 R4: mid-bank burst in another mode
        ices = 1'b0; oces = 1'b0;
        wbuf[0] = 8'h01; wbuf[1] = 8'h80; wbuf[2] = 8'hE7;
        write_regs(5'd20, 3, 1'b1);
        read_regs(5'd20, 3, 1'b1, "R8 R4 mid-bank burst");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule